// File: doc/BRIEF.md
# Expanded-Memory Page Mapper with Per-Window Extended Mode

This block translates CPU accesses in four memory windows into addresses for a 4 MB paged RAM. Each window owns an 8-bit page register, and a fifth register holds one extended-mode bit per window. The host programs the registers through a small I/O write port: an offset, a data byte and a write strobe. Each memory cycle presents a window index, a 14-bit offset inside the window and an active-low select. From these the block forms a 22-bit RAM address and an active-low RAM chip select.

A window whose extended bit is clear behaves like a 2 MB board. Any page value with bit 7 set leaves that window unmapped, so software can disable a window by writing 0xFF. A window whose extended bit is set treats page bit 7 as the top RAM address bit and reaches the upper 2 MB. The chip select depends only on the current memory-cycle inputs and the register contents.

Top module: `emsx_mapper`

## Requirements
- R1: Synchronous active-high reset sets every page register to 0xFF and every extended bit to 0, so no window asserts the chip select after reset.
- R2: An I/O write with offset 0 to 3 loads the data byte into the page register of window 0 to 3, and the new value is visible from the clock edge that samples the strobe onward. It is not visible before that edge.
- R3: An I/O write with offset 4 loads data bits 3:0 as the extended bits of windows 0 to 3 (bit n for window n), and data bits 7:4 are ignored.
- R4: The RAM address equals {page register of the addressed window, window offset}, with the offset in bits 13:0.
- R5: With the select low and the addressed window's extended bit 0, the chip select is low when page bit 7 is 0.
- R6: With the addressed window's extended bit 0 and page bit 7 equal to 1, the chip select stays high (the window is unmapped).
- R7: With the addressed window's extended bit 1 and the select low, the chip select is low for either value of page bit 7, and RAM address bit 21 equals page bit 7.
- R8: With the select high, the chip select is high whatever the register contents.
- R9: An I/O write with offset 5, 6 or 7 changes no register.
- R10: Only the extended bit of the window that the current cycle addresses affects the chip select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_wr | input | 1 | I/O write strobe, sampled on the rising edge |
| io_addr | input | 3 | I/O register offset from the block's base |
| io_data | input | 8 | I/O write data |
| mem_sel_n | input | 1 | Memory-cycle select, active low |
| mem_win | input | 2 | Index of the window the cycle addresses |
| mem_ofs | input | 14 | Byte offset inside the 16 KB window |
| ram_addr | output | 22 | Physical RAM address |
| ram_cs_n | output | 1 | RAM chip select, active low |

## Verification
The mapping is tried with pages that have bit 7 clear and with pages that have it set, first in compatibility mode and then in extended mode. This shows the one case that unmaps apart from the three cases that map. Enable patterns that set the bit of one window only, and patterns that set only data bits 7:4, show whether the decision follows the addressed window and ignores the upper nibble. Offset sweeps across windows with distinct page values show whether the address concatenation and the window selection are correct. Writes to the unused offsets, and cycles with the select held high, confirm that neither one changes the output.

// File: rtl/emsx_pkg.sv
package emsx_pkg;
    localparam int NUM_WIN  = 4;
    localparam int PAGE_W   = 8;
    localparam int OFS_W    = 14;
    localparam int IO_AW    = 3;
    localparam int WIN_W    = $clog2(NUM_WIN);
    localparam int ADDR_W   = PAGE_W + OFS_W;
    localparam int EXT_OFS  = NUM_WIN;
    localparam logic [PAGE_W-1:0] PAGE_RST = '1;

    typedef logic [PAGE_W-1:0] page_t;
    typedef logic [WIN_W-1:0]  win_t;
    typedef logic [OFS_W-1:0]  ofs_t;

    typedef struct packed {
        logic sel_n;
        win_t win;
        ofs_t ofs;
    } mem_cycle_t;

    typedef struct packed {
        page_t page;
        ofs_t  ofs;
    } ram_addr_t;

    // Low result means the RAM is selected.
    function automatic logic cs_decide(input logic sel_n, input logic ext, input logic page_msb);
        return sel_n | (~ext & page_msb);
    endfunction
endpackage

// File: rtl/emsx_page_regs.sv
module emsx_page_regs
    import emsx_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       io_wr,
    input  logic [IO_AW-1:0]           io_addr,
    input  logic [PAGE_W-1:0]          io_data,
    output logic [NUM_WIN-1:0][PAGE_W-1:0] pages,
    output logic [NUM_WIN-1:0]         ext_en
);
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_page
        always_ff @(posedge clk) begin
            if (rst) begin
                pages[w] <= PAGE_RST;
            end else if (io_wr && io_addr == IO_AW'(w)) begin
                pages[w] <= io_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_en <= '0;
        end else if (io_wr && io_addr == IO_AW'(EXT_OFS)) begin
            ext_en <= io_data[NUM_WIN-1:0];
        end
    end
endmodule

// File: rtl/emsx_cs_gate.sv
module emsx_cs_gate
    import emsx_pkg::*;
(
    input  logic sel_n,
    input  logic ext,
    input  logic page_msb,
    output logic cs_n
);
    always_comb begin
        cs_n = cs_decide(sel_n, ext, page_msb);
    end
endmodule

// File: rtl/emsx_mapper.sv
module emsx_mapper
    import emsx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 io_wr,
    input  logic [IO_AW-1:0]     io_addr,
    input  logic [PAGE_W-1:0]    io_data,
    input  logic                 mem_sel_n,
    input  logic [WIN_W-1:0]     mem_win,
    input  logic [OFS_W-1:0]     mem_ofs,
    output logic [ADDR_W-1:0]    ram_addr,
    output logic                 ram_cs_n
);
    logic [NUM_WIN-1:0][PAGE_W-1:0] pages;
    logic [NUM_WIN-1:0]             ext_en;
    mem_cycle_t                     cyc;
    ram_addr_t                      phys;
    page_t                          cur_page;
    logic                           cur_ext;

    emsx_page_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .io_wr   (io_wr),
        .io_addr (io_addr),
        .io_data (io_data),
        .pages   (pages),
        .ext_en  (ext_en)
    );

    always_comb begin
        cyc.sel_n = mem_sel_n;
        cyc.win   = mem_win;
        cyc.ofs   = mem_ofs;
        cur_page  = pages[cyc.win];
        cur_ext   = ext_en[cyc.win];
        phys.page = cur_page;
        phys.ofs  = cyc.ofs;
        ram_addr  = phys;
    end

    emsx_cs_gate u_gate (
        .sel_n    (cyc.sel_n),
        .ext      (cur_ext),
        .page_msb (cur_page[PAGE_W-1]),
        .cs_n     (ram_cs_n)
    );
endmodule

// File: rtl/emsx_mapper_chk.sv
module emsx_mapper_chk
    import emsx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 io_wr,
    input  logic [IO_AW-1:0]     io_addr,
    input  logic [PAGE_W-1:0]    io_data,
    input  logic                 mem_sel_n,
    input  logic [WIN_W-1:0]     mem_win,
    input  logic [OFS_W-1:0]     mem_ofs,
    input  logic [ADDR_W-1:0]    ram_addr,
    input  logic                 ram_cs_n
);
    logic [PAGE_W-1:0] data_q;
    logic              ext_wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q   <= '0;
            ext_wr_q <= 1'b0;
        end else begin
            data_q   <= io_data;
            ext_wr_q <= io_wr && io_addr == IO_AW'(EXT_OFS);
        end
    end

    AST_IDLE_NO_SELECT: assert property (@(posedge clk) disable iff (rst)
        mem_sel_n |-> ram_cs_n); // R8

    AST_OFFSET_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
        ram_addr[OFS_W-1:0] == mem_ofs); // R4

    AST_PAGE_LOADED: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_addr < IO_AW'(NUM_WIN)) |=>
        (IO_AW'(mem_win) != $past(io_addr) || ram_addr[ADDR_W-1:OFS_W] == $past(io_data))); // R2

    AST_EXT_ALWAYS_MAPS: assert property (@(posedge clk) disable iff (rst)
        ext_wr_q |-> (mem_sel_n || !data_q[mem_win] || !ram_cs_n)); // R7

    AST_SELECT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        !ram_cs_n |-> !mem_sel_n); // R8
endmodule

bind emsx_mapper emsx_mapper_chk u_chk (.*);

// File: tb/tb_emsx_mapper.sv
`timescale 1ns/1ps
module tb_emsx_mapper;
    logic        clk = 1'b0;
    logic        rst;
    logic        io_wr;
    logic [2:0]  io_addr;
    logic [7:0]  io_data;
    logic        mem_sel_n;
    logic [1:0]  mem_win;
    logic [13:0] mem_ofs;
    logic [21:0] ram_addr;
    logic        ram_cs_n;

    int checks = 0;
    int failures = 0;
    int m_page [4];
    int m_ext;
    bit cmp_on = 0;

    always #4 clk = ~clk;

    emsx_mapper dut (
        .clk(clk), .rst(rst), .io_wr(io_wr), .io_addr(io_addr), .io_data(io_data),
        .mem_sel_n(mem_sel_n), .mem_win(mem_win), .mem_ofs(mem_ofs),
        .ram_addr(ram_addr), .ram_cs_n(ram_cs_n)
    );

    // Behavioural reference: register state updated on each edge.
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4; i++) m_page[i] = 255;
            m_ext = 0;
        end else if (io_wr) begin
            if (io_addr < 4) m_page[io_addr] = io_data;
            else if (io_addr == 4) m_ext = io_data % 16;
        end
    end

    function automatic int exp_addr();
        return m_page[mem_win] * 16384 + mem_ofs;
    endfunction

    function automatic bit exp_cs();
        bit ext_on;
        ext_on = ((m_ext / (1 << mem_win)) % 2) == 1;
        if (mem_sel_n) return 1'b1;
        if (ext_on) return 1'b0;
        return m_page[mem_win] >= 128;
    endfunction

    always @(negedge clk) begin
        if (cmp_on) begin
            checks++;
            if (ram_addr !== 22'(exp_addr())) begin
                failures++;
                $display("FAIL R4 per-clock address: actual=%h expected=%h", ram_addr, 22'(exp_addr()));
            end
            checks++;
            if (ram_cs_n !== exp_cs()) begin
                failures++;
                $display("FAIL R5 per-clock select: actual=%b expected=%b", ram_cs_n, exp_cs());
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic io_write(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        io_wr = 1'b1; io_addr = a; io_data = d;
        @(posedge clk); #1;
        io_wr = 1'b0;
    endtask

    task automatic look(input logic [1:0] w, input logic [13:0] o, input logic s);
        mem_win = w; mem_ofs = o; mem_sel_n = s;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; io_wr = 1'b0; io_addr = '0; io_data = '0;
        mem_sel_n = 1'b1; mem_win = '0; mem_ofs = '0;
        repeat (3) @(posedge clk); #1;
        rst = 1'b0;
        cmp_on = 1;

        // R1: everything unmapped after reset
        for (int w = 0; w < 4; w++) begin
            look(2'(w), 14'h0123, 1'b0);
            check(ram_cs_n === 1'b1, "R1 reset cs", ram_cs_n, 1);
            check(ram_addr[21:14] === 8'hFF, "R1 reset page", ram_addr[21:14], 8'hFF);
        end

        // R2: timing, old value before the edge, new after
        @(posedge clk); #1;
        io_wr = 1'b1; io_addr = 3'd0; io_data = 8'h12;
        look(2'd0, 14'h0000, 1'b0);
        check(ram_addr[21:14] === 8'hFF, "R2 not before edge", ram_addr[21:14], 8'hFF);
        @(posedge clk); #1; io_wr = 1'b0;
        look(2'd0, 14'h3FFF, 1'b0);
        check(ram_addr === {8'h12, 14'h3FFF}, "R2 after edge", ram_addr, {8'h12, 14'h3FFF});
        check(ram_cs_n === 1'b0, "R5 compat low page maps", ram_cs_n, 0);

        io_write(3'd1, 8'h85);
        io_write(3'd2, 8'h7F);
        io_write(3'd3, 8'hC0);
        look(2'd2, 14'h2AAA, 1'b0);
        check(ram_addr === {8'h7F, 14'h2AAA}, "R4 window 2 address", ram_addr, {8'h7F, 14'h2AAA});
        check(ram_cs_n === 1'b0, "R5 page 7F maps", ram_cs_n, 0);
        look(2'd1, 14'h0001, 1'b0);
        check(ram_cs_n === 1'b1, "R6 compat page 85 unmapped", ram_cs_n, 1);
        look(2'd3, 14'h0001, 1'b0);
        check(ram_cs_n === 1'b1, "R6 compat page C0 unmapped", ram_cs_n, 1);

        // R3: upper nibble ignored
        io_write(3'd4, 8'hF0);
        look(2'd1, 14'h0001, 1'b0);
        check(ram_cs_n === 1'b1, "R3 upper nibble ignored", ram_cs_n, 1);

        // R10 / R7: enable window 1 only
        io_write(3'd4, 8'h02);
        look(2'd1, 14'h1234, 1'b0);
        check(ram_cs_n === 1'b0, "R7 extended maps upper half", ram_cs_n, 0);
        check(ram_addr[21] === 1'b1, "R7 A21 from page bit 7", ram_addr[21], 1);
        look(2'd3, 14'h1234, 1'b0);
        check(ram_cs_n === 1'b1, "R10 other window stays compat", ram_cs_n, 1);
        look(2'd1, 14'h1234, 1'b1);
        check(ram_cs_n === 1'b1, "R8 select high", ram_cs_n, 1);

        io_write(3'd4, 8'h0A);
        io_write(3'd1, 8'h05);
        look(2'd1, 14'h0000, 1'b0);
        check(ram_cs_n === 1'b0 && ram_addr[21] === 1'b0, "R7 extended low half", ram_cs_n, 0);
        look(2'd3, 14'h0000, 1'b0);
        check(ram_cs_n === 1'b0, "R3 bit 3 enables window 3", ram_cs_n, 0);

        // R9: unused offsets
        io_write(3'd5, 8'h00);
        io_write(3'd6, 8'h00);
        io_write(3'd7, 8'h00);
        look(2'd3, 14'h0010, 1'b0);
        check(ram_addr === {8'hC0, 14'h0010} && ram_cs_n === 1'b0, "R9 unused offsets", ram_addr, {8'hC0, 14'h0010});
        look(2'd0, 14'h0010, 1'b0);
        check(ram_addr[21:14] === 8'h12, "R9 page 0 kept", ram_addr[21:14], 8'h12);

        // disable via FF in compat mode
        io_write(3'd0, 8'hFF);
        look(2'd0, 14'h0000, 1'b0);
        check(ram_cs_n === 1'b1, "R6 FF disables window", ram_cs_n, 1);

        // R1 again: reset mid-run
        @(posedge clk); #1; rst = 1'b1;
        @(posedge clk); #1; rst = 1'b0;
        look(2'd3, 14'h0000, 1'b0);
        check(ram_cs_n === 1'b1, "R1 reset clears extended", ram_cs_n, 1);

        // sweep offsets and windows
        io_write(3'd4, 8'h05);
        for (int p = 0; p < 4; p++) io_write(3'(p), 8'(p * 67 + 100));
        for (int k = 0; k < 64; k++) look(2'(k % 4), 14'(k * 251), 1'(k % 5 == 0));

        cmp_on = 0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule